// File: doc/BRIEF.md
# Receive Byte Stream to AXI4-Stream Adapter

This block sits behind a legacy receive MAC interface that delivers frame bytes with a single valid strobe and reports the frame outcome later, as a separate good pulse or bad pulse after the data has ended. It converts that traffic into a byte-wide AXI4-Stream source with no back-pressure. The downstream consumer must accept each beat on the cycle it appears.

To place tlast on the real final byte, the adapter keeps one byte in a holding register. Each byte is forwarded only when the next byte arrives. When the valid strobe drops, the held byte is known to be the last one. It is not forwarded yet. The output goes idle (tvalid low) until the verdict pulse arrives. The last byte then appears with tlast high and tuser carrying the frame status, so a consumer finds the end of the frame and its status on the same beat.

At reduced line rates the legacy side is paced by a clock enable. The adapter acts only on enabled cycles, and its tvalid is high for a single clock per forwarded byte. If no verdict comes within a bounded number of enabled cycles, the frame is closed as bad.

Top module: `rx_stream_adapter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_tvalid, out_tlast and out_tuser are all low.
- R2: Frame bytes appear on out_tdata in arrival order. Every byte except the last has out_tlast low and out_tuser low. A byte is forwarded on the enabled cycle in which the following byte is accepted.
- R3: Exactly one beat per frame has out_tlast high, and it carries the final byte of that frame. out_tlast is never high without out_tvalid.
- R4: The final beat is withheld until a verdict pulse arrives on an enabled cycle. out_tuser on that beat is 0 for a good frame (in_good) and 1 for a bad frame (in_bad). out_tuser is high only on a beat with out_tlast high.
- R5: If in_good and in_bad are high together, the frame is reported as bad (out_tuser = 1).
- R6: If no verdict arrives, the final beat is emitted with out_tuser = 1 on the VERDICT_TIMEOUT-th enabled cycle after the enabled cycle in which in_valid was first seen low. A verdict that arrives on that cycle still decides the status.
- R7: On a clock where ce is low, all inputs are ignored and out_tvalid is low on the following cycle.
- R8: A verdict pulse when no frame is pending produces no beat. Bytes presented while the adapter is waiting for a verdict are discarded.
- R9: A verdict that arrives on the same enabled cycle in which in_valid falls closes the frame at once. A one-byte frame is emitted as a single beat with out_tlast high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable pacing the legacy side |
| in_data | input | DATA_W | Received byte |
| in_valid | input | 1 | High while frame bytes are presented |
| in_good | input | 1 | Frame-good pulse after the data |
| in_bad | input | 1 | Frame-bad pulse after the data |
| out_tdata | output | DATA_W | Stream data |
| out_tvalid | output | 1 | Stream beat valid, one clock per byte |
| out_tlast | output | 1 | Final byte of the frame |
| out_tuser | output | 1 | Frame bad, meaningful with out_tlast |

## Verification
The scoreboard checks frames of one, two and many bytes at full rate and with the enable alternating. Garbage is driven on disabled cycles, which separates correct enable gating from sampling on every clock. The verdict is tried with a good pulse, a bad pulse, both pulses together, a good pulse on the cycle valid falls, a good pulse on the last cycle of the window, and no pulse at all. These cases separate correct status selection from a fixed status, and a correct timeout boundary from an off-by-one. Stray verdicts between frames and stray bytes during the wait show whether the adapter ignores input outside the state where it is meaningful.

// File: rtl/rx_stream_adapter.sv
module rx_stream_adapter #(
  parameter int DATA_W          = 8,
  parameter int VERDICT_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_good,
  input  logic              in_bad,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tvalid,
  output logic              out_tlast,
  output logic              out_tuser
);
  localparam int CNT_W = $clog2(VERDICT_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(VERDICT_TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WAIT} state_t;

  state_t            state;
  logic [DATA_W-1:0] hold;
  logic [CNT_W-1:0]  wait_cnt;
  logic              verdict;

  assign verdict = in_good | in_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      hold       <= '0;
      wait_cnt   <= '0;
      out_tdata  <= '0;
      out_tvalid <= 1'b0;
      out_tlast  <= 1'b0;
      out_tuser  <= 1'b0;
    end else begin
      out_tvalid <= 1'b0;
      out_tlast  <= 1'b0;
      out_tuser  <= 1'b0;
      if (ce) begin
        case (state)
          S_IDLE: if (in_valid) begin
            hold  <= in_data;
            state <= S_FILL;
          end
          S_FILL: begin
            if (in_valid) begin
              out_tdata  <= hold;
              out_tvalid <= 1'b1;
              hold       <= in_data;
            end else if (verdict) begin
              out_tdata  <= hold;
              out_tvalid <= 1'b1;
              out_tlast  <= 1'b1;
              out_tuser  <= in_bad;
              state      <= S_IDLE;
            end else begin
              wait_cnt <= '0;
              state    <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (verdict || wait_cnt == CNT_END) begin
              out_tdata  <= hold;
              out_tvalid <= 1'b1;
              out_tlast  <= 1'b1;
              out_tuser  <= in_bad | ~in_good;
              state      <= S_IDLE;
            end else begin
              wait_cnt <= wait_cnt + CNT_W'(1);
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_tlast |-> out_tvalid);

  assert_user_only_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_tuser |-> out_tlast);

  assert_quiet_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !out_tvalid);

  assert_both_pulses_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && state == S_WAIT && in_good && in_bad) |=> (out_tvalid && out_tlast && out_tuser));

  assert_timeout_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && state == S_WAIT && !in_good && !in_bad && wait_cnt == CNT_END)
      |=> (out_tlast && out_tuser));

  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |=> !out_tvalid);
endmodule

// File: tb/test_rx_stream_adapter.sv
module test_rx_stream_adapter;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_good = 1'b0, in_bad = 1'b0;
  logic [7:0] out_tdata;
  logic out_tvalid, out_tlast, out_tuser;

  always #10 clk = ~clk;

  rx_stream_adapter #(.DATA_W(8), .VERDICT_TIMEOUT(T)) i_rx_stream_adapter (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_data(in_data), .in_valid(in_valid),
    .in_good(in_good), .in_bad(in_bad), .out_tdata(out_tdata),
    .out_tvalid(out_tvalid), .out_tlast(out_tlast), .out_tuser(out_tuser));

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  bit slow = 0;
  bit done = 0;
  int pcount = 0;
  int fall_t = 0, last_t = 0;
  logic ce_q = 1'b1;

  always @(posedge clk) begin
    pcount <= pcount + 1;
    ce_q <= ce;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!out_tvalid && !out_tlast && !out_tuser, "R1 reset outputs",
            {out_tvalid, out_tlast, out_tuser}, 0);
    end else begin
      if (out_tvalid && !ce_q) check(0, "R7 beat after disabled cycle", 1, 0);
      if (out_tvalid) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected beat", {out_tuser, out_tlast, out_tdata}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(out_tdata == e[7:0], "R2 byte order", out_tdata, e[7:0]);
          check(out_tlast == e[8], "R3 tlast position", out_tlast, e[8]);
          check(out_tuser == e[9], "R4 frame status", out_tuser, e[9]);
          if (out_tlast) last_t = pcount;
        end
      end
    end
  end

  task automatic cyc(input logic [7:0] d, input logic v, input logic g, input logic b);
    if (slow) begin
      @(negedge clk);
      ce = 1'b0; in_data = ~d; in_valid = ~v; in_good = 1'b1; in_bad = 1'b1;
    end
    @(negedge clk);
    ce = 1'b1; in_data = d; in_valid = v; in_good = g; in_bad = b;
  endtask

  // mode: 0 good, 1 bad, 2 both, 3 none, 4 good on fall cycle
  task automatic send_frame(input int len, input logic [7:0] base, input int mode, input int gap);
    for (int i = 0; i < len; i++) begin
      bit user;
      user = (i == len - 1) && !(mode == 0 || mode == 4);
      exp_q.push_back({user, i == len - 1, 8'(base + i)});
    end
    for (int i = 0; i < len; i++) cyc(8'(base + i), 1'b1, 1'b0, 1'b0);
    if (mode == 4) begin
      cyc(8'h00, 1'b0, 1'b1, 1'b0);
    end else if (mode == 3) begin
      cyc(8'h00, 1'b0, 1'b0, 1'b0);
      fall_t = pcount;
      for (int i = 0; i < T + 3; i++) cyc(8'h00, 1'b0, 1'b0, 1'b0);
    end else begin
      for (int i = 0; i < gap; i++)
        cyc(8'hEE, (i == 1), 1'b0, 1'b0);  // R8 stray byte while waiting
      cyc(8'h00, 1'b0, mode != 1, mode != 0);
    end
    for (int i = 0; i < 3; i++) cyc(8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_tvalid && !out_tlast && !out_tuser, "R1 after reset",
          {out_tvalid, out_tlast, out_tuser}, 0);
    for (int s = 0; s < 2; s++) begin
      slow = (s == 1);
      send_frame(6, 8'h10, 0, 2);          // R4 good
      send_frame(5, 8'h40, 1, 3);          // R4 bad
      send_frame(3, 8'h70, 2, 1);          // R5 both
      send_frame(1, 8'hA0, 4, 0);          // R9 single byte, verdict on fall
      send_frame(4, 8'hB0, 4, 0);          // R9 verdict on fall
      cyc(8'h55, 1'b0, 1'b1, 1'b1);        // R8 stray verdict in idle
      cyc(8'h00, 1'b0, 1'b0, 1'b0);
      send_frame(2, 8'hC0, 0, T);          // R6 verdict on last window cycle
      send_frame(7, 8'hD0, 3, 0);          // R6 timeout
      if (!slow) check(last_t - fall_t == T + 1, "R6 timeout latency", last_t - fall_t, T + 1);
      send_frame(9, 8'hE0, 0, 1);          // R2 long frame after timeout
    end
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all frames closed", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule